// File: doc/BRIEF.md
# ECC Error Status Logger

This block covers the error-checking side of a memory controller whose stored words are 72 bits wide: 64 data bits and 8 check bits. A combinational encoder builds the check bits for data about to be written. For each word read back, the block computes a syndrome and an overall parity. From these it sorts the word into one of three classes: no error, single-bit error or uncorrectable (double-bit) error. When correction is enabled, a single flipped bit is repaired. Every read word comes out one cycle later as a reply beat, and an uncorrectable word raises a flag on its own beat.

The first error seen after a clear is logged. Its class and syndrome go into a status word and its address into a failing-address register. Both stay frozen until software clears them. Any further error before the clear only sets a sticky multiple-error bit.

A small configuration write port controls the block. Index 0 holds the correction enable and index 3 is the clear command.

Top module: `ecc_err_logger`

## Requirements
- R1: Codeword bit positions run from 0 to 71. Position 0 holds overall parity and positions 1, 2, 4, 8, 16, 32 and 64 hold the syndrome check bits. Data bit j sits at the j-th remaining position in ascending order, so data bit 0 is at position 3. An encoded word has even parity and the XOR of the indices of its set bits is zero. For example, data 1 encodes to 72'hF.
- R2: With correction enabled, a single flipped bit at any of the 72 positions is corrected: the reply data equals the original data and the reply is not flagged.
- R3: Status bits [11:5] hold the logged syndrome. For a single-bit error this is the index of the flipped position. For a double-bit error it is the XOR of the two indices.
- R4: A word with odd parity and a syndrome below 72 is a single-bit error and sets status bit 1. Any other nonzero check result is uncorrectable and sets status bit 3. The first logged error sets exactly one of these two bits. Status bits 2 and 4 always read 0.
- R5: An error detected while an error is already logged sets status bit 0. Two single-bit errors give low status bits 5'd3. Two double-bit errors give 5'd9.
- R6: The class, syndrome and failing address of the first error stay unchanged until a clear, even when later errors of either class arrive.
- R7: A configuration write to index 3 sets the status and the failing address to 0. An error presented in the same cycle as the clear is not logged.
- R8: Each read word appears on the reply outputs exactly one cycle later. The uncorrectable flag is high only on the reply beat whose word is uncorrectable.
- R9: Bit 0 of a configuration write to index 0 is the correction enable, which is 1 after reset. When it is 0, reply data is the raw stored data bits, while detection and logging work as before.
- R10: After reset, the status is 0, the failing address is 0, the reply valid is low and correction is enabled.
- R11: Configuration writes to indices 1 and 2 change neither the status, the failing address nor the correction enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 64 | Data to encode |
| enc_word_o | output | 72 | Encoded codeword |
| rd_valid_i | input | 1 | A stored word is presented for checking |
| rd_word_i | input | 72 | Stored codeword read from memory |
| rd_addr_i | input | ADDR_W (32) | Address of the stored word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Configuration index (0 enable, 3 clear) |
| cfg_wdata_i | input | 1 | Configuration write bit |
| rd_valid_o | output | 1 | Reply beat valid |
| rd_data_o | output | 64 | Reply data (corrected when enabled) |
| rd_uerr_o | output | 1 | Reply beat carries an uncorrectable word |
| status_o | output | 12 | Error status word |
| fail_addr_o | output | ADDR_W (32) | Address of the first logged error |

## Verification
The assertions assume that every checked word has at most two flipped bits. A word with three or more flips can look like a valid single-bit error, and the class logic cannot tell the difference. They also assume that all inputs are known from reset onward. The stimulus only flips zero, one or two distinct positions of words built by the block's own encoder. It drives every input from the first clock, so the frozen-log and clear properties see only well-defined histories.

// File: rtl/eccl_pkg.sv
package eccl_pkg;
    localparam int DATA_W  = 64;
    localparam int CODE_W  = 72;
    localparam int SYN_W   = $clog2(CODE_W);
    localparam int SYN_LSB = 5;
    localparam int STAT_W  = SYN_LSB + SYN_W;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_DOUBLE = 2'd2
    } err_class_e;

    typedef struct packed {
        err_class_e       cls;
        logic [SYN_W-1:0] syn;
    } chk_res_t;

    function automatic bit is_chk_pos(int p);
        return (p == 0) || ((p & (p - 1)) == 0);
    endfunction

    function automatic int data_pos(int j);
        int n;
        n = 0;
        for (int p = 0; p < CODE_W; p++) begin
            if (!is_chk_pos(p)) begin
                if (n == j) return p;
                n++;
            end
        end
        return 0;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(logic mult, logic single,
                                                      logic dbl, logic [SYN_W-1:0] syn);
        return {syn, 1'b0, dbl, 1'b0, single, mult};
    endfunction
endpackage

// File: rtl/eccl_encode.sv
module eccl_encode
    import eccl_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] word_o
);
    always_comb begin
        logic [SYN_W-1:0]  s;
        logic [CODE_W-1:0] w;
        w = '0;
        s = '0;
        for (int j = 0; j < DATA_W; j++) begin
            w[data_pos(j)] = data_i[j];
            if (data_i[j]) s = s ^ SYN_W'(data_pos(j));
        end
        for (int k = 0; k < SYN_W; k++) begin
            if ((1 << k) < CODE_W) w[1 << k] = s[k];
        end
        w[0] = ^w[CODE_W-1:1];
        word_o = w;
    end
endmodule

// File: rtl/eccl_check.sv
module eccl_check
    import eccl_pkg::*;
(
    input  logic [CODE_W-1:0] word_i,
    input  logic              corr_en_i,
    output logic [DATA_W-1:0] data_o,
    output chk_res_t          res_o
);
    logic [SYN_W-1:0]  syn;
    logic              par;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (word_i[i]) syn = syn ^ SYN_W'(i);
        end
        par = ^word_i;
    end

    always_comb begin
        res_o.syn = syn;
        if (!par && syn == '0)
            res_o.cls = ERR_NONE;
        else if (par && 32'(syn) < CODE_W)
            res_o.cls = ERR_SINGLE;
        else
            res_o.cls = ERR_DOUBLE;
    end

    always_comb begin
        fixed = word_i;
        if (corr_en_i && res_o.cls == ERR_SINGLE) fixed[syn] = ~word_i[syn];
        for (int j = 0; j < DATA_W; j++) data_o[j] = fixed[data_pos(j)];
    end
endmodule

// File: rtl/eccl_log.sv
module eccl_log
    import eccl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              log_i,
    input  chk_res_t          res_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output logic [STAT_W-1:0] status_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic             mult_q, single_q, dbl_q;
    logic [SYN_W-1:0] syn_q;
    logic [ADDR_W-1:0] addr_q;
    logic             seen;

    assign seen = single_q | dbl_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            mult_q   <= 1'b0;
            single_q <= 1'b0;
            dbl_q    <= 1'b0;
            syn_q    <= '0;
            addr_q   <= '0;
        end else if (log_i) begin
            if (!seen) begin
                single_q <= (res_i.cls == ERR_SINGLE);
                dbl_q    <= (res_i.cls != ERR_SINGLE);
                syn_q    <= res_i.syn;
                addr_q   <= addr_i;
            end else begin
                mult_q <= 1'b1;
            end
        end
    end

    assign status_o = pack_status(mult_q, single_q, dbl_q, syn_q);
    assign addr_o   = addr_q;

    p_class_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(single_q && dbl_q));
    p_mult_after_first_r5: assert property (@(posedge clk) disable iff (rst)
        mult_q |-> seen);
    p_log_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && !clr_i) |=> ($stable(syn_q) && $stable(addr_q) && $stable({single_q, dbl_q})));
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (status_o == '0 && addr_o == '0));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import eccl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       enc_data_i,
    output logic [71:0]       enc_word_o,
    input  logic              rd_valid_i,
    input  logic [71:0]       rd_word_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_idx_i,
    input  logic              cfg_wdata_i,
    output logic              rd_valid_o,
    output logic [63:0]       rd_data_o,
    output logic              rd_uerr_o,
    output logic [11:0]       status_o,
    output logic [ADDR_W-1:0] fail_addr_o
);
    localparam logic [1:0] IDX_ENABLE = 2'd0;
    localparam logic [1:0] IDX_CLEAR  = 2'd3;

    logic              corr_en_q;
    logic              clr;
    logic [DATA_W-1:0] chk_data;
    chk_res_t          chk_res;

    assign clr = cfg_we_i && (cfg_idx_i == IDX_CLEAR);

    always_ff @(posedge clk) begin
        if (rst)
            corr_en_q <= 1'b1;
        else if (cfg_we_i && cfg_idx_i == IDX_ENABLE)
            corr_en_q <= cfg_wdata_i;
    end

    eccl_encode u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_o)
    );

    eccl_check u_chk (
        .word_i    (rd_word_i),
        .corr_en_i (corr_en_q),
        .data_o    (chk_data),
        .res_o     (chk_res)
    );

    eccl_log #(.ADDR_W(ADDR_W)) u_log (
        .clk      (clk),
        .rst      (rst),
        .log_i    (rd_valid_i && chk_res.cls != ERR_NONE),
        .res_i    (chk_res),
        .addr_i   (rd_addr_i),
        .clr_i    (clr),
        .status_o (status_o),
        .addr_o   (fail_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_uerr_o  <= 1'b0;
        end else begin
            rd_valid_o <= rd_valid_i;
            rd_data_o  <= chk_data;
            rd_uerr_o  <= rd_valid_i && chk_res.cls == ERR_DOUBLE;
        end
    end

    p_uerr_on_beat_r8: assert property (@(posedge clk) disable iff (rst)
        rd_uerr_o |-> rd_valid_o);
    p_beat_follows_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid_i |=> rd_valid_o);
endmodule

// File: tb/tb_ecc_err_logger.sv
module tb_ecc_err_logger;
    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] enc_data_i = '0;
    logic [71:0] enc_word_o;
    logic        rd_valid_i = 0;
    logic [71:0] rd_word_i = '0;
    logic [31:0] rd_addr_i = '0;
    logic        cfg_we_i = 0;
    logic [1:0]  cfg_idx_i = '0;
    logic        cfg_wdata_i = 0;
    logic        rd_valid_o;
    logic [63:0] rd_data_o;
    logic        rd_uerr_o;
    logic [11:0] status_o;
    logic [31:0] fail_addr_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ecc_err_logger dut (.*);

    localparam int NV = 7;
    localparam logic [63:0] TV_DATA [NV] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
        64'hDEAD_BEEF_0000_0001, 64'h5555_5555_5555_5555, 64'h0F0F_1234_8000_0007,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002};
    localparam int TV_A [NV] = '{-1, 0, 62, 71, 62, 0, 3};
    localparam int TV_B [NV] = '{-1, -1, -1, -1, 66, 71, -1};
    localparam logic [31:0] TV_ADDR [NV] = '{32'h100, 32'h0F0, 32'h1234, 32'hFFFF_FFF0,
        32'h0F0, 32'h8, 32'h40};

    task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] encode(logic [63:0] d);
        enc_data_i = d;
        return '0;
    endfunction

    task automatic get_word(input logic [63:0] d, output logic [71:0] w);
        enc_data_i = d;
        #1;
        w = enc_word_o;
    endtask

    task automatic cfg(input logic [1:0] idx, input logic v);
        @(negedge clk);
        cfg_we_i = 1; cfg_idx_i = idx; cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 0;
    endtask

    task automatic send(input logic [71:0] w, input logic [31:0] a);
        @(negedge clk);
        rd_valid_i = 1; rd_word_i = w; rd_addr_i = a;
        @(negedge clk);
        rd_valid_i = 0;
    endtask

    function automatic logic [71:0] flip(logic [71:0] w, int a, int b);
        logic [71:0] r;
        r = w;
        if (a >= 0) r[a] = ~r[a];
        if (b >= 0) r[b] = ~r[b];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [71:0] w, w2;
        logic [11:0] exp_st;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10 status", 72'(status_o), 72'h0);
        chk("R10 addr", 72'(fail_addr_o), 72'h0);
        chk("R10 valid", 72'(rd_valid_o), 72'h0);

        // R1 code layout
        get_word(64'h1, w);
        chk("R1 encode data 1", w, 72'hF);
        get_word(64'h0, w);
        chk("R1 encode zero", w, 72'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            cfg(2'd3, 1'b0);
            get_word(TV_DATA[v], w);
            send(flip(w, TV_A[v], TV_B[v]), TV_ADDR[v]);
            chk("R8 beat valid", 72'(rd_valid_o), 72'h1);
            if (TV_A[v] < 0) begin
                exp_st = '0;
                chk("R1 clean word data", 72'(rd_data_o), 72'(TV_DATA[v]));
                chk("R3 clean addr", 72'(fail_addr_o), 72'h0);
            end else if (TV_B[v] < 0) begin
                exp_st = 12'((TV_A[v] << 5) | 2);
                chk("R2 corrected data", 72'(rd_data_o), 72'(TV_DATA[v]));
                chk("R8 no uerr single", 72'(rd_uerr_o), 72'h0);
                chk("R3 addr", 72'(fail_addr_o), 72'(TV_ADDR[v]));
            end else begin
                exp_st = 12'(((TV_A[v] ^ TV_B[v]) << 5) | 8);
                chk("R8 uerr double", 72'(rd_uerr_o), 72'h1);
                chk("R3 addr", 72'(fail_addr_o), 72'(TV_ADDR[v]));
            end
            chk("R3 R4 status", 72'(status_o), 72'(exp_st));
        end

        // R2 every position
        get_word(64'hA5A5_3C3C_0FF0_9669, w);
        for (int p = 0; p < 72; p++) begin
            cfg(2'd3, 1'b0);
            send(flip(w, p, -1), 32'(p));
            chk("R2 sweep data", 72'(rd_data_o), 72'h00A5A5_3C3C_0FF0_9669);
            chk("R3 sweep syndrome", 72'(status_o), 72'((p << 5) | 2));
        end

        // R5 two singles, R6 freeze
        cfg(2'd3, 1'b0);
        send(flip(w, 62, -1), 32'h0F0);
        send(flip(w, 10, -1), 32'h555);
        chk("R5 two singles", 72'(status_o), 72'((62 << 5) | 3));
        chk("R6 addr frozen", 72'(fail_addr_o), 72'h0F0);
        send(flip(w, 5, 9), 32'h777);
        chk("R6 single then double", 72'(status_o), 72'((62 << 5) | 3));
        chk("R6 addr after double", 72'(fail_addr_o), 72'h0F0);

        // R5 two doubles
        cfg(2'd3, 1'b0);
        send(flip(w, 62, 66), 32'h0F0);
        send(flip(w, 1, 2), 32'h111);
        chk("R5 two doubles", 72'(status_o), 72'(((62 ^ 66) << 5) | 9));

        // R7 clear in same cycle as error
        @(negedge clk);
        cfg_we_i = 1; cfg_idx_i = 2'd3; rd_valid_i = 1;
        rd_word_i = flip(w, 7, -1); rd_addr_i = 32'h99;
        @(negedge clk);
        cfg_we_i = 0; rd_valid_i = 0;
        chk("R7 clear wins status", 72'(status_o), 72'h0);
        chk("R7 clear wins addr", 72'(fail_addr_o), 72'h0);

        // R11 writes to 1 and 2 ignored
        send(flip(w, 20, -1), 32'h2222);
        cfg(2'd1, 1'b0);
        cfg(2'd2, 1'b0);
        chk("R11 status kept", 72'(status_o), 72'((20 << 5) | 2));
        chk("R11 addr kept", 72'(fail_addr_o), 72'h2222);
        cfg(2'd3, 1'b0);
        send(flip(w, 3, -1), 32'h4);
        chk("R11 correction still on", 72'(rd_data_o), 72'h00A5A5_3C3C_0FF0_9669);

        // R9 correction disabled: data bit 0 at position 3 stays flipped
        cfg(2'd0, 1'b0);
        cfg(2'd3, 1'b0);
        send(flip(w, 3, -1), 32'h44);
        chk("R9 raw data", 72'(rd_data_o), 72'h00A5A5_3C3C_0FF0_9668);
        chk("R9 still logged", 72'(status_o), 72'((3 << 5) | 2));
        chk("R9 addr logged", 72'(fail_addr_o), 72'h44);
        cfg(2'd0, 1'b1);

        // R8 burst: only beat 2 flagged
        get_word(64'h1111_2222_3333_4444, w2);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            if (b > 0) chk("R8 burst flag", 72'(rd_uerr_o), 72'(b - 1 == 2));
            rd_valid_i = 1; rd_addr_i = 32'(b);
            rd_word_i = (b == 2) ? flip(w2, 30, 40) : w2;
        end
        @(negedge clk);
        rd_valid_i = 0;
        chk("R8 burst last beat", 72'(rd_uerr_o), 72'h0);
        @(negedge clk);
        chk("R8 idle after burst", 72'(rd_valid_o), 72'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule